// File: doc/BRIEF.md
# Aligned Line-Pair Prefetcher

This block generates prefetches for a cache with 64-byte lines. Every demand fill into the cache names a line. That line and one other line together make a naturally aligned 128-byte pair, and the block computes this partner line. The partner is found by inverting address bit 6 of the filled line. It can sit above or below the demand line. The block does not wait for a second miss to confirm a pattern: the first fill is enough to produce a candidate. The prefetch it asks for targets the same cache level that took the fill.

Each candidate passes through three stages:

- **Load throttle.** When the outstanding-miss count is above a threshold that can be changed at run time, no candidate is made.
- **Tag probe.** A candidate whose line is already resident is discarded.
- **Pending queue.** Candidates that survive the probe wait in a small FIFO. A candidate that matches a waiting entry is discarded. A candidate that arrives while the queue is full is discarded.

The queue drives one prefetch request port that it shares with demand traffic. Demand traffic always has priority.

Top module: `pair_prefetcher`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `probe_valid` and `pf_valid` low and an empty queue. The throttle threshold returns to `THR_RESET`, which is 8 in the bench.
- R2: A fill accepted at edge N gives `probe_valid` high in the cycle after N. `probe_addr` is the fill address with bits 5:0 cleared and bit 6 inverted, so the target may be the lower line of the pair.
- R3: A fill is dropped without a probe when `miss_cnt` is strictly greater than the current threshold. A count equal to the threshold still produces a candidate.
- R4: When `cfg_thr_we` is high at an edge, `cfg_thr` becomes the threshold used for fills sampled at every later edge.
- R5: A probe cycle with `probe_hit` high adds nothing to the queue.
- R6: A candidate whose line equals a line already waiting in the queue is dropped.
- R7: The queue holds at most `DEPTH` lines (4 by default). A candidate that finds the queue full is dropped.
- R8: While `dmd_req` is high, `pf_valid` is low and the queue keeps its contents and order.
- R9: Whenever the queue is non-empty and `dmd_req` is low, `pf_valid` is high with the oldest line on `pf_addr` (bits 5:0 zero). That line leaves the queue at the next edge, so lines go out one per cycle in arrival order.
- R10: A single isolated fill, with no earlier miss nearby, leads to exactly one prefetch of its partner line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | A demand line fill occurs this cycle |
| fill_addr | input | ADDR_W | Byte address of the filled line |
| miss_cnt | input | CNT_W | Current number of outstanding misses |
| cfg_thr_we | input | 1 | Load a new throttle threshold |
| cfg_thr | input | CNT_W | New throttle threshold value |
| probe_valid | output | 1 | Tag probe request for the candidate line |
| probe_addr | output | ADDR_W | Line-aligned address being probed |
| probe_hit | input | 1 | Probed line is resident; valid in the same cycle as `probe_valid` |
| dmd_req | input | 1 | Demand traffic owns the downstream port this cycle |
| pf_valid | output | 1 | Prefetch request issued this cycle |
| pf_addr | output | ADDR_W | Line-aligned prefetch target |

## Verification
The bench builds the block with `DEPTH=4`, `CNT_W=4` and `THR_RESET=8`. A four-entry queue can be filled by a handful of fills while `dmd_req` is held high. This reaches the full-queue drop and the duplicate drop quickly. A 4-bit miss count covers values on both sides of the threshold, including equality.

Probe hits come from a fixed rule on address bits 9:8. The random phase draws fills from 32 lines, so resident partners, repeated pairs and partners on both sides of the pair all occur often.

// File: rtl/pair_pf_pkg.sv
package pair_pf_pkg;

  // Fate of a candidate in the probe cycle, in priority order.
  typedef enum logic [2:0] {
    V_NONE = 3'd0,
    V_HIT  = 3'd1,
    V_DUP  = 3'd2,
    V_FULL = 3'd3,
    V_PUSH = 3'd4
  } pf_verdict_e;

  // Partner of a line inside its aligned pair: flip the lowest line bit.
  function automatic logic pair_bit_flip(input logic b);
    return ~b;
  endfunction

endpackage

// File: rtl/pfp_trigger.sv
module pfp_trigger #(
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = 6,
  parameter int CNT_W     = 6,
  parameter int THR_RESET = 8,
  localparam int LA_W     = ADDR_W - LINE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_valid,
  input  logic [LA_W-1:0]  fill_line,
  input  logic [CNT_W-1:0] miss_cnt,
  input  logic             cfg_thr_we,
  input  logic [CNT_W-1:0] cfg_thr,
  output logic             cand_valid,
  output logic [LA_W-1:0]  cand_line
);
  import pair_pf_pkg::*;

  logic [CNT_W-1:0] thr_q;
  logic             over_load;

  assign over_load = miss_cnt > thr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q      <= CNT_W'(THR_RESET);
      cand_valid <= 1'b0;
      cand_line  <= '0;
    end else begin
      if (cfg_thr_we) thr_q <= cfg_thr;
      cand_valid <= fill_valid && !over_load;
      cand_line  <= {fill_line[LA_W-1:1], pair_bit_flip(fill_line[0])};
    end
  end

  p_throttle_r3: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && (miss_cnt > thr_q)) |=> !cand_valid);

  p_partner_r2: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !(miss_cnt > thr_q)) |=>
      (cand_valid && (cand_line[0] != $past(fill_line[0]))
       && (cand_line[LA_W-1:1] == $past(fill_line[LA_W-1:1]))));

  p_cfg_load_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_thr_we |=> (thr_q == $past(cfg_thr)));

endmodule

// File: rtl/pfp_filter.sv
module pfp_filter (
  input  logic                     cand_valid,
  input  logic                     probe_hit,
  input  logic                     dup_hit,
  input  logic                     q_full,
  output pair_pf_pkg::pf_verdict_e verdict,
  output logic                     push
);
  import pair_pf_pkg::*;

  always_comb begin
    if (!cand_valid)   verdict = V_NONE;
    else if (probe_hit) verdict = V_HIT;
    else if (dup_hit)   verdict = V_DUP;
    else if (q_full)    verdict = V_FULL;
    else                verdict = V_PUSH;
  end

  assign push = (verdict == V_PUSH);

endmodule

// File: rtl/pfp_queue.sv
module pfp_queue #(
  parameter int LA_W   = 26,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [LA_W-1:0] push_line,
  input  logic            pop,
  input  logic [LA_W-1:0] cmp_line,
  output logic            dup_hit,
  output logic            full,
  output logic            head_valid,
  output logic [LA_W-1:0] head_line
);

  logic [LA_W-1:0]  ent [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [PTR_W:0]   count;
  logic [DEPTH-1:0] match_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [PTR_W-1:0] rel;
    logic             live;
    assign rel          = PTR_W'(i) - rd_ptr;
    assign live         = {1'b0, rel} < count;
    assign match_vec[i] = live && (ent[i] == cmp_line);
  end

  assign dup_hit    = |match_vec;
  assign full       = (count == (PTR_W+1)'(DEPTH));
  assign head_valid = (count != '0);
  assign head_line  = ent[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) ent[wr_ptr] <= push_line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    count <= (PTR_W+1)'(DEPTH));

  p_no_dup_push_r6: assert property (@(posedge clk) disable iff (rst)
    push |-> !dup_hit);

  p_hold_head_r8: assert property (@(posedge clk) disable iff (rst)
    (head_valid && !pop) |=> (head_valid && $stable(head_line)));

endmodule

// File: rtl/pair_prefetcher.sv
module pair_prefetcher #(
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = 6,
  parameter int CNT_W     = 6,
  parameter int DEPTH     = 4,
  parameter int THR_RESET = 8,
  localparam int LA_W     = ADDR_W - LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [CNT_W-1:0]  miss_cnt,
  input  logic              cfg_thr_we,
  input  logic [CNT_W-1:0]  cfg_thr,
  output logic              probe_valid,
  output logic [ADDR_W-1:0] probe_addr,
  input  logic              probe_hit,
  input  logic              dmd_req,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  import pair_pf_pkg::*;

  logic            cand_valid;
  logic [LA_W-1:0] cand_line;
  logic            dup_hit, q_full, q_push, q_pop, head_valid;
  logic [LA_W-1:0] head_line;
  pf_verdict_e     verdict;

  pfp_trigger #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .CNT_W(CNT_W), .THR_RESET(THR_RESET)
  ) u_trigger (
    .clk(clk), .rst(rst),
    .fill_valid(fill_valid), .fill_line(fill_addr[ADDR_W-1:LINE_W]),
    .miss_cnt(miss_cnt), .cfg_thr_we(cfg_thr_we), .cfg_thr(cfg_thr),
    .cand_valid(cand_valid), .cand_line(cand_line)
  );

  pfp_filter u_filter (
    .cand_valid(cand_valid), .probe_hit(probe_hit), .dup_hit(dup_hit),
    .q_full(q_full), .verdict(verdict), .push(q_push)
  );

  pfp_queue #(.LA_W(LA_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .push(q_push), .push_line(cand_line), .pop(q_pop),
    .cmp_line(cand_line), .dup_hit(dup_hit), .full(q_full),
    .head_valid(head_valid), .head_line(head_line)
  );

  assign q_pop       = head_valid && !dmd_req;
  assign pf_valid    = q_pop;
  assign pf_addr     = {head_line, {LINE_W{1'b0}}};
  assign probe_valid = cand_valid;
  assign probe_addr  = {cand_line, {LINE_W{1'b0}}};

  p_hit_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (probe_valid && probe_hit) |-> !q_push);

  p_dmd_wins_r8: assert property (@(posedge clk) disable iff (rst)
    dmd_req |-> !pf_valid);

  p_push_has_verdict_r9: assert property (@(posedge clk) disable iff (rst)
    q_push |-> (verdict == V_PUSH) && probe_valid);

endmodule

// File: tb/pair_prefetcher_bench.sv
module pair_prefetcher_bench;
  localparam int AW = 32, LW = 6, CW = 4, DEP = 4, THR0 = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic fill_valid = 1'b0, cfg_thr_we = 1'b0, dmd_req = 1'b0, hit_en = 1'b1;
  logic [AW-1:0] fill_addr = '0;
  logic [CW-1:0] miss_cnt = '0, cfg_thr = '0;
  logic probe_valid, probe_hit, pf_valid;
  logic [AW-1:0] probe_addr, pf_addr;

  int checks = 0, fails = 0;
  bit cmp_en = 1'b0;
  logic [AW-1:0] obs[$];

  // Environment: a line is resident when its address bits 9:8 are both set.
  assign probe_hit = probe_valid && hit_en && (probe_addr[9:8] == 2'b11);

  always #10 clk = ~clk;

  pair_prefetcher #(.ADDR_W(AW), .LINE_W(LW), .CNT_W(CW), .DEPTH(DEP),
                    .THR_RESET(THR0)) u_pair_prefetcher (
    .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .miss_cnt(miss_cnt), .cfg_thr_we(cfg_thr_we), .cfg_thr(cfg_thr),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_hit(probe_hit),
    .dmd_req(dmd_req), .pf_valid(pf_valid), .pf_addr(pf_addr));

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit            m_cv;
  logic [25:0]   m_cl;
  int            m_thr;
  logic [25:0]   mq[$];

  function automatic bit in_q(input logic [25:0] l);
    foreach (mq[k]) if (mq[k] == l) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cv = 1'b0; m_cl = '0; m_thr = THR0; mq.delete();
    end else begin
      bit hit, popq;
      hit  = m_cv && hit_en && (m_cl[3:2] == 2'b11);
      popq = (mq.size() > 0) && !dmd_req;
      if (m_cv && !hit && !in_q(m_cl) && mq.size() < DEP) begin
        if (popq) void'(mq.pop_front());
        mq.push_back(m_cl);
      end else if (popq) void'(mq.pop_front());
      m_cv = fill_valid && !(int'(miss_cnt) > m_thr);
      m_cl = fill_addr[AW-1:LW] ^ 26'd1;
      if (cfg_thr_we) m_thr = int'(cfg_thr);
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    #1;
    if (cmp_en) begin
      bit ev;
      ev = (mq.size() > 0) && !dmd_req;
      chk(probe_valid == m_cv, "R3 probe_valid", AW'(probe_valid), AW'(m_cv));
      if (m_cv) chk(probe_addr == {m_cl, 6'd0}, "R2 probe_addr", probe_addr, {m_cl, 6'd0});
      chk(pf_valid == ev, "R8 pf_valid", AW'(pf_valid), AW'(ev));
      if (ev) chk(pf_addr == {mq[0], 6'd0}, "R9 pf_addr", pf_addr, {mq[0], 6'd0});
      if (pf_valid) obs.push_back(pf_addr);
    end
  end

  task automatic cyc(input bit fv, input logic [AW-1:0] fa, input bit dm,
                     input int cnt);
    @(negedge clk);
    fill_valid = fv; fill_addr = fa; dmd_req = dm; miss_cnt = CW'(cnt);
    cfg_thr_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, 0);
  endtask

  task automatic set_thr(input int v);
    @(negedge clk);
    fill_valid = 1'b0; dmd_req = 1'b0; cfg_thr_we = 1'b1; cfg_thr = CW'(v);
  endtask

  task automatic expect_obs(input string tag, input int n,
                            input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                            input logic [AW-1:0] a2, input logic [AW-1:0] a3);
    logic [AW-1:0] e[4];
    e = '{a0, a1, a2, a3};
    chk(obs.size() == n, tag, AW'(obs.size()), AW'(n));
    for (int i = 0; i < n && i < obs.size(); i++)
      chk(obs[i] == e[i], tag, obs[i], e[i]);
    obs.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!probe_valid && !pf_valid, "R1 reset outputs",
        AW'({probe_valid, pf_valid}), '0);
    rst = 1'b0;
    cmp_en = 1'b1;
    idle(2);
    obs.delete();

    // R10 and R2: partner below, then above
    cyc(1'b1, 32'h1000_0052, 1'b0, 0); idle(5);
    expect_obs("R10 lower partner", 1, 32'h1000_0000, 0, 0, 0);
    cyc(1'b1, 32'h2000_0000, 1'b0, 0); idle(5);
    expect_obs("R2 upper partner", 1, 32'h2000_0040, 0, 0, 0);

    // R3 with the R1 reset threshold of 8
    cyc(1'b1, 32'h3000_0000, 1'b0, 9); idle(5);
    expect_obs("R3 above threshold", 0, 0, 0, 0, 0);
    cyc(1'b1, 32'h3000_0080, 1'b0, 8); idle(5);
    expect_obs("R3 equal threshold", 1, 32'h3000_00C0, 0, 0, 0);

    // R4 threshold reprogram
    set_thr(2);
    cyc(1'b1, 32'h5000_0000, 1'b0, 3); idle(5);
    expect_obs("R4 new limit blocks", 0, 0, 0, 0, 0);
    cyc(1'b1, 32'h5000_0000, 1'b0, 2); idle(5);
    expect_obs("R4 new limit passes", 1, 32'h5000_0040, 0, 0, 0);

    // R5 resident partner
    cyc(1'b1, 32'h0000_0340, 1'b0, 0); idle(5);
    expect_obs("R5 probe hit", 0, 0, 0, 0, 0);

    // R8 hold, R6 duplicate, R7 full
    cyc(1'b1, 32'h6000_0000, 1'b1, 0);
    cyc(1'b1, 32'h6000_0000, 1'b1, 0);
    cyc(1'b1, 32'h6000_0400, 1'b1, 0);
    cyc(1'b1, 32'h6000_0800, 1'b1, 0);
    cyc(1'b1, 32'h6000_0C00, 1'b1, 0);
    cyc(1'b1, 32'h6000_1000, 1'b1, 0);
    cyc(1'b1, 32'h6000_1400, 1'b1, 0);
    cyc(1'b0, '0, 1'b1, 0);
    cyc(1'b0, '0, 1'b1, 0);
    chk(obs.size() == 0, "R8 held under demand", AW'(obs.size()), '0);
    idle(8);
    expect_obs("R7 R6 R9 drain order", 4, 32'h6000_0040, 32'h6000_0440,
               32'h6000_0840, 32'h6000_0C40);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 50) == 0) set_thr($urandom_range(0, 15));
      else begin
        hit_en = ($urandom % 4) != 0;
        cyc(($urandom % 3) != 0,
            AW'($urandom_range(0, 31) << 6) | AW'($urandom_range(0, 63)),
            ($urandom % 5) < 2, $urandom_range(0, 15));
      end
    end
    idle(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule